// File: doc/BRIEF.md
# Flash Write Sequencer

This block carries out the memory-altering commands of a serial flash device behind an already decoded command interface. A neighbouring decoder presents one command per strobe as an 8-bit operation code, a 24-bit address and a data byte. The sequencer checks the command against the write-enable latch, the block-protection level and its own state. It then holds `busy_o` high for a self-timed interval, given as a cycle count, and commits the change to the byte array when the interval ends. Program operations can only turn bits from 1 to 0. Erase operations return a whole region to FFh.

The array is held in registers. `ADDR_W` sets its size: 17 gives the full 128 KB device, and the small default keeps simulation cheap. Sector and block sizes scale through `SECT_BITS` and `BLK_BITS`. Protection always covers the top quarter, the top half or the whole of the address space. An auto-increment mode programs consecutive bytes. The mode needs an address only on its first command and leaves by itself at the top address. The owner of the write-enable latch clears it when it sees `wel_clr_o`. A read port shows the array contents.

Top module: `flash_wr_seq`

## Requirements
- R1: Every write-type command (02h, AFh, 20h, 52h, 60h) presented while `wel_i` is 0 is ignored: `busy_o` stays 0 and the array keeps its contents.
- R2: Byte program (op 02h) stores the bitwise AND of the old byte and `cmd_data` at `cmd_addr[ADDR_W-1:0]`; address bits above `ADDR_W` are ignored.
- R3: Sector erase (op 20h) sets to FFh every byte whose bits `[ADDR_W-1:SECT_BITS]` equal those of the address; all other bytes are untouched.
- R4: Block erase (op 52h) sets to FFh every byte whose bits `[ADDR_W-1:BLK_BITS]` equal those of the address; all other bytes are untouched.
- R5: Chip erase (op 60h) sets the whole array to FFh, and is ignored unless `bp_i` is 00.
- R6: With `bp_i` = 01 the top quarter (two address MSBs both 1) is protected, with 10 the top half (MSB 1), and with 11 everything; a program or erase whose target address is protected is ignored.
- R7: An accepted command raises `busy_o` in the cycle after the strobe. `busy_o` stays high for exactly `T_PROG` cycles for a program, `T_ERASE` for a sector or block erase and `T_CHIP` for a chip erase. The array changes when `busy_o` falls.
- R8: `wel_clr_o` is a one-cycle pulse in the first cycle after `busy_o` falls, for a byte program and for every erase. It is not raised after an auto-increment byte that is not at the top address.
- R9: An AFh command while `aai_o` is 0 programs its own address and sets `aai_o` from the next cycle. Each AFh while `aai_o` is 1 programs the byte after the previous one and ignores `cmd_addr`. Auto-increment bytes do not raise `wel_clr_o`.
- R10: Write disable (op 04h) drives `aai_o` to 0 in the next cycle.
- R11: When the auto-increment byte at the highest address completes, `aai_o` returns to 0 and `wel_clr_o` pulses. The pointer does not wrap to address 0.
- R12: Write-type commands are ignored while `busy_o` is 1, and commands 02h, 20h, 52h and 60h are ignored while `aai_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; array returns to FFh |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 8 | Operation code |
| cmd_addr | input | 24 | Byte address; only the low `ADDR_W` bits are used |
| cmd_data | input | 8 | Data byte for program commands |
| wel_i | input | 1 | Current write-enable latch |
| bp_i | input | 2 | Block-protection level |
| rd_addr | input | ADDR_W | Read-port address |
| rd_data | output | 8 | Array byte at `rd_addr` (combinational) |
| busy_o | output | 1 | Internal operation in progress |
| aai_o | output | 1 | Auto-increment programming mode active |
| wel_clr_o | output | 1 | Request to clear the write-enable latch |

## Verification
A wrong acceptance decision is seen as early as possible: `busy_o` rises, or fails to rise, in the cycle after the strobe. A corrupted interval counter shows as a busy pulse of the wrong length when `busy_o` falls. Damage from a wrong region mask or a stale pointer stays hidden until the array is read. For that reason the whole read port is swept against a predicted image after each operation, which also catches writes to bytes that should not have changed. Mode-flag mistakes show on `aai_o` within one cycle, or as a `wel_clr_o` pulse at the wrong end of an operation.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
   typedef enum logic [2:0] {
      K_NONE = 3'd0,
      K_PROG = 3'd1,
      K_SECT = 3'd2,
      K_BLK  = 3'd3,
      K_CHIP = 3'd4
   } op_kind_e;

   localparam logic [7:0] OPC_PROG = 8'h02;
   localparam logic [7:0] OPC_AAI  = 8'hAF;
   localparam logic [7:0] OPC_SECT = 8'h20;
   localparam logic [7:0] OPC_BLK  = 8'h52;
   localparam logic [7:0] OPC_CHIP = 8'h60;
   localparam logic [7:0] OPC_WRDI = 8'h04;
endpackage

// File: rtl/fpe_guard.sv
module fpe_guard
   import fpe_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              valid,
   input  logic [7:0]        op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] ptr,
   input  logic              aai_on,
   input  logic              wel,
   input  logic [1:0]        bp,
   input  logic              busy,
   output logic              accept,
   output op_kind_e          kind,
   output logic [ADDR_W-1:0] tgt,
   output logic              aai_start
);
   function automatic logic prot_f(input logic [ADDR_W-1:0] a, input logic [1:0] lvl);
      unique case (lvl)
         2'd0:    return 1'b0;
         2'd1:    return &a[ADDR_W-1:ADDR_W-2];
         2'd2:    return a[ADDR_W-1];
         default: return 1'b1;
      endcase
   endfunction

   logic is_aai, free, open_tgt;

   assign is_aai   = (op == OPC_AAI);
   assign tgt      = (is_aai && aai_on) ? ptr : addr;
   assign free     = valid && !busy && wel;
   assign open_tgt = !prot_f(tgt, bp);

   always_comb begin
      accept = 1'b0;
      kind   = K_NONE;
      unique case (op)
         OPC_PROG: begin accept = free && !aai_on && open_tgt; kind = K_PROG; end
         OPC_AAI:  begin accept = free && open_tgt;            kind = K_PROG; end
         OPC_SECT: begin accept = free && !aai_on && open_tgt; kind = K_SECT; end
         OPC_BLK:  begin accept = free && !aai_on && open_tgt; kind = K_BLK;  end
         OPC_CHIP: begin accept = free && !aai_on && (bp == 2'b00); kind = K_CHIP; end
         default:  ;
      endcase
   end

   assign aai_start = accept && is_aai && !aai_on;
endmodule

// File: rtl/fpe_timer.sv
module fpe_timer
   import fpe_pkg::*;
#(
   parameter int T_PROG  = 2000,
   parameter int T_ERASE = 2500000,
   parameter int T_CHIP  = 10000000
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  op_kind_e kind,
   output logic     busy,
   output logic     done
);
   localparam int T_MAX0 = (T_PROG > T_ERASE) ? T_PROG : T_ERASE;
   localparam int T_MAX  = (T_MAX0 > T_CHIP) ? T_MAX0 : T_CHIP;
   localparam int CW     = $clog2(T_MAX + 1);

   logic [CW-1:0] cnt, lim;
   logic          busy_q;

   always_comb begin
      unique case (kind)
         K_SECT, K_BLK: lim = CW'(T_ERASE);
         K_CHIP:        lim = CW'(T_CHIP);
         default:       lim = CW'(T_PROG);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt    <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt    <= lim - 1'b1;
      end else if (busy_q) begin
         if (cnt == '0) busy_q <= 1'b0;
         else           cnt    <= cnt - 1'b1;
      end
   end

   assign busy = busy_q;
   assign done = busy_q && (cnt == '0);
endmodule

// File: rtl/fpe_array.sv
module fpe_array
   import fpe_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int SECT_BITS = 6,
   parameter int BLK_BITS  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  op_kind_e          kind,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DEPTH*8-1:0] flat;

   for (genvar i = 0; i < DEPTH; i++) begin : g_byte
      localparam logic [ADDR_W-1:0] IA = ADDR_W'(i);
      logic [7:0] q;
      logic       sect_hit, blk_hit;

      assign sect_hit = (addr[ADDR_W-1:SECT_BITS] == IA[ADDR_W-1:SECT_BITS]);
      assign blk_hit  = (addr[ADDR_W-1:BLK_BITS]  == IA[ADDR_W-1:BLK_BITS]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= 8'hFF;
         end else if (wr_en) begin
            unique case (kind)
               K_PROG:  if (addr == IA) q <= q & data;
               K_SECT:  if (sect_hit)   q <= 8'hFF;
               K_BLK:   if (blk_hit)    q <= 8'hFF;
               K_CHIP:  q <= 8'hFF;
               default: ;
            endcase
         end
      end

      assign flat[i*8 +: 8] = q;
   end

   assign rd_data = flat[{rd_addr, 3'b000} +: 8];
endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq
   import fpe_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int SECT_BITS = 6,
   parameter int BLK_BITS  = 8,
   parameter int T_PROG    = 2000,
   parameter int T_ERASE   = 2500000,
   parameter int T_CHIP    = 10000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_op,
   input  logic [23:0]       cmd_addr,
   input  logic [7:0]        cmd_data,
   input  logic              wel_i,
   input  logic [1:0]        bp_i,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              busy_o,
   output logic              aai_o,
   output logic              wel_clr_o
);
   localparam logic [ADDR_W-1:0] TOP_A = '1;

   if (ADDR_W < 3 || ADDR_W > 24) begin : g_bad_aw
      $error("flash_wr_seq: ADDR_W must lie in 3..24");
   end
   if (SECT_BITS < 1 || SECT_BITS > BLK_BITS || BLK_BITS > ADDR_W - 2) begin : g_bad_geo
      $error("flash_wr_seq: need 1 <= SECT_BITS <= BLK_BITS <= ADDR_W-2");
   end
   if (T_PROG < 1 || T_ERASE < 1 || T_CHIP < 1) begin : g_bad_t
      $error("flash_wr_seq: interval limits must be at least 1");
   end

   logic [ADDR_W-1:0] addr_m, tgt, ptr_q, pend_addr;
   logic [7:0]        pend_data;
   op_kind_e          kind, pend_kind;
   logic              accept, aai_start, busy, done;
   logic              pend_aai, aai_q, clr_q;

   assign addr_m = cmd_addr[ADDR_W-1:0];

   fpe_guard #(.ADDR_W(ADDR_W)) u_guard (
      .valid     (cmd_valid),
      .op        (cmd_op),
      .addr      (addr_m),
      .ptr       (ptr_q),
      .aai_on    (aai_q),
      .wel       (wel_i),
      .bp        (bp_i),
      .busy      (busy),
      .accept    (accept),
      .kind      (kind),
      .tgt       (tgt),
      .aai_start (aai_start)
   );

   fpe_timer #(.T_PROG(T_PROG), .T_ERASE(T_ERASE), .T_CHIP(T_CHIP)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .kind  (kind),
      .busy  (busy),
      .done  (done)
   );

   fpe_array #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .BLK_BITS(BLK_BITS)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (done),
      .kind    (pend_kind),
      .addr    (pend_addr),
      .data    (pend_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_kind <= K_NONE;
         pend_addr <= '0;
         pend_data <= 8'hFF;
         pend_aai  <= 1'b0;
         ptr_q     <= '0;
         aai_q     <= 1'b0;
         clr_q     <= 1'b0;
      end else begin
         clr_q <= 1'b0;
         if (accept) begin
            pend_kind <= kind;
            pend_addr <= tgt;
            pend_data <= cmd_data;
            pend_aai  <= (cmd_op == OPC_AAI);
         end
         if (done) begin
            clr_q <= !pend_aai || (pend_addr == TOP_A);
            if (pend_aai) ptr_q <= pend_addr + 1'b1;
         end
         if (cmd_valid && cmd_op == OPC_WRDI)          aai_q <= 1'b0;
         else if (aai_start)                           aai_q <= 1'b1;
         else if (done && pend_aai && pend_addr == TOP_A) aai_q <= 1'b0;
      end
   end

   assign busy_o    = busy;
   assign aai_o     = aai_q;
   assign wel_clr_o = clr_q;
endmodule

// File: rtl/flash_wr_seq_chk.sv
module flash_wr_seq_chk #(
   parameter int T_PROG  = 2000,
   parameter int T_ERASE = 2500000,
   parameter int T_CHIP  = 10000000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [7:0] cmd_op,
   input logic       wel_i,
   input logic [1:0] bp_i,
   input logic       busy_o,
   input logic       aai_o,
   input logic       wel_clr_o
);
   int run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_len <= 0;
      else if (busy_o) run_len <= run_len + 1;
      else             run_len <= 0;
   end

   // R1
   no_wel_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !wel_i && !busy_o) |=> !busy_o);

   // R5
   chip_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 8'h60 && bp_i != 2'b00 && !busy_o) |=> !busy_o);

   // R7
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (run_len == T_PROG || run_len == T_ERASE || run_len == T_CHIP));

   // R8
   clr_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wel_clr_o |-> (!busy_o && $past(busy_o)));

   // R9
   aai_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(aai_o) |-> $past(cmd_valid && cmd_op == 8'hAF && wel_i));

   // R10
   wrdi_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 8'h04) |=> !aai_o);

   // R12
   busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !$past(busy_o)) |-> !wel_clr_o);
endmodule

bind flash_wr_seq flash_wr_seq_chk #(
   .T_PROG  (T_PROG),
   .T_ERASE (T_ERASE),
   .T_CHIP  (T_CHIP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .wel_i     (wel_i),
   .bp_i      (bp_i),
   .busy_o    (busy_o),
   .aai_o     (aai_o),
   .wel_clr_o (wel_clr_o)
);

// File: tb/test_flash_wr_seq.sv
`timescale 1ns/100ps
module test_flash_wr_seq;
   localparam int AW = 10;
   localparam int DEPTH = 1 << AW;
   localparam int TP = 5, TE = 9, TC = 13;

   typedef struct {
      int    len;
      bit    clr;
      string tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [7:0]    cmd_op = 8'h00;
   logic [23:0]   cmd_addr = '0;
   logic [7:0]    cmd_data = 8'h00;
   logic          wel_i = 1'b1;
   logic [1:0]    bp_i = 2'b00;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;
   logic          busy_o, aai_o, wel_clr_o;

   int   n_chk = 0, n_fail = 0;
   bit   done_run = 0;
   exp_t exq[$];
   logic [7:0] mdl [DEPTH];

   always #2.5 clk = ~clk;

   flash_wr_seq #(.ADDR_W(AW), .SECT_BITS(6), .BLK_BITS(8),
                  .T_PROG(TP), .T_ERASE(TE), .T_CHIP(TC)) i_flash_wr_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wel_i(wel_i), .bp_i(bp_i),
      .rd_addr(rd_addr), .rd_data(rd_data), .busy_o(busy_o), .aai_o(aai_o),
      .wel_clr_o(wel_clr_o));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_run) begin
         done_run = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // scoreboard monitor: measures each busy pulse and compares with queue
   initial begin
      int len = 0;
      exp_t e;
      forever begin
         @(negedge clk);
         if (!rst_n) len = 0;
         else if (busy_o) len++;
         else if (len > 0) begin
            if (exq.size() == 0) chk(1'b0, "R7 unexpected busy pulse", len, 0);
            else begin
               e = exq.pop_front();
               chk(len == e.len, {e.tag, " busy length"}, len, e.len);
               chk(wel_clr_o == e.clr, {e.tag, " wel_clr pulse"}, int'(wel_clr_o), int'(e.clr));
            end
            len = 0;
         end
      end
   end

   task automatic issue(input logic [7:0] op, input logic [23:0] a, input logic [7:0] d,
                        input bit acc, input int len, input bit clr, input string tag);
      exp_t e;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
      if (acc) begin
         e.len = len; e.clr = clr; e.tag = tag;
         exq.push_back(e);
      end
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy_o) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic expect_idle(input string tag);
      @(negedge clk);
      chk(busy_o == 1'b0, tag, int'(busy_o), 0);
   endtask

   task automatic check_mem(input string tag);
      int bad = 0, first = -1;
      for (int a = 0; a < DEPTH; a++) begin
         rd_addr = AW'(a);
         #0.1;
         if (rd_data !== mdl[a]) begin
            if (bad == 0) first = a;
            bad++;
         end
      end
      if (bad != 0) $display("  first mismatch at %0h: %0h vs %0h", first, i_flash_wr_seq.rd_data, mdl[first]);
      chk(bad == 0, {tag, " array image (mismatch count)"}, bad, 0);
   endtask

   task automatic fill_range(input int lo, input int hi);
      for (int a = lo; a <= hi; a++) mdl[a] = 8'hFF;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int a = 0; a < DEPTH; a++) mdl[a] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(busy_o == 0 && aai_o == 0 && wel_clr_o == 0, "R7 reset outputs idle",
          {busy_o, aai_o, wel_clr_o}, 0);
      check_mem("R3 reset");

      // R1: no write enable
      wel_i = 1'b0;
      issue(8'h02, 24'h000005, 8'h00, 0, 0, 0, "R1");
      expect_idle("R1 program without wel");
      issue(8'h60, 24'h0, 8'h00, 0, 0, 0, "R1");
      expect_idle("R1 chip erase without wel");
      check_mem("R1");
      wel_i = 1'b1;

      // R2: program, AND, masking
      issue(8'h02, 24'h000010, 8'hA5, 1, TP, 1, "R2 program"); mdl[16'h10] = 8'hA5;
      wait_idle();
      issue(8'h02, 24'h000010, 8'h3C, 1, TP, 1, "R2 and"); mdl[16'h10] = 8'h24;
      wait_idle();
      issue(8'h02, 24'h012011, 8'h0F, 1, TP, 1, "R2 masked"); mdl[16'h11] = 8'h0F;
      wait_idle();
      check_mem("R2");

      // R12: second command while busy is ignored
      issue(8'h02, 24'h000040, 8'h00, 1, TP, 1, "R12 first"); mdl[16'h40] = 8'h00;
      issue(8'h02, 24'h000041, 8'h00, 0, 0, 0, "R12 during busy");
      wait_idle();
      check_mem("R12 busy");

      // R3: sector erase of sector 0
      issue(8'h20, 24'h000015, 8'h00, 1, TE, 1, "R3 sector"); fill_range(0, 63);
      wait_idle();
      check_mem("R3");

      // R4: block erase 0x100..0x1FF
      issue(8'h02, 24'h000100, 8'h11, 1, TP, 1, "R4 setup"); mdl[16'h100] = 8'h11; wait_idle();
      issue(8'h02, 24'h0001FF, 8'h22, 1, TP, 1, "R4 setup"); mdl[16'h1FF] = 8'h22; wait_idle();
      issue(8'h02, 24'h000200, 8'h33, 1, TP, 1, "R4 setup"); mdl[16'h200] = 8'h33; wait_idle();
      issue(8'h52, 24'h000150, 8'h00, 1, TE, 1, "R4 block"); fill_range(16'h100, 16'h1FF);
      wait_idle();
      check_mem("R4");

      // R6: protection levels
      bp_i = 2'b01;
      issue(8'h02, 24'h000300, 8'h00, 0, 0, 0, "R6");
      expect_idle("R6 top quarter program ignored");
      issue(8'h02, 24'h0002FF, 8'h5A, 1, TP, 1, "R6 below quarter"); mdl[16'h2FF] = 8'h5A;
      wait_idle();
      bp_i = 2'b10;
      issue(8'h20, 24'h000210, 8'h00, 0, 0, 0, "R6");
      expect_idle("R6 top half erase ignored");
      bp_i = 2'b11;
      issue(8'h02, 24'h000000, 8'h00, 0, 0, 0, "R6");
      expect_idle("R6 full protection ignored");
      check_mem("R6");

      // R5: chip erase gated by protection
      bp_i = 2'b01;
      issue(8'h60, 24'h0, 8'h00, 0, 0, 0, "R5");
      expect_idle("R5 chip erase with bp=01 ignored");
      check_mem("R5 locked");
      bp_i = 2'b00;
      issue(8'h60, 24'h0, 8'h00, 1, TC, 1, "R5 chip"); fill_range(0, DEPTH - 1);
      wait_idle();
      check_mem("R5");

      // R9: auto-increment sequence
      issue(8'hAF, 24'h000020, 8'h12, 1, TP, 0, "R9 first"); mdl[16'h20] = 8'h12;
      chk(aai_o == 1'b1, "R9 mode entered", int'(aai_o), 1);
      wait_idle();
      issue(8'hAF, 24'h000300, 8'h34, 1, TP, 0, "R9 second"); mdl[16'h21] = 8'h34;
      wait_idle();
      issue(8'hAF, 24'h000000, 8'h56, 1, TP, 0, "R9 third"); mdl[16'h22] = 8'h56;
      wait_idle();
      chk(aai_o == 1'b1, "R9 mode held", int'(aai_o), 1);
      // R12: plain program ignored in auto-increment mode
      issue(8'h02, 24'h000050, 8'h00, 0, 0, 0, "R12");
      expect_idle("R12 program in aai mode ignored");
      check_mem("R9");
      // R10: write disable
      issue(8'h04, 24'h0, 8'h00, 0, 0, 0, "R10");
      chk(aai_o == 1'b0, "R10 mode left", int'(aai_o), 0);

      // R11: top address exit, no wrap
      issue(8'hAF, 24'h0003FE, 8'hC3, 1, TP, 0, "R11 first"); mdl[16'h3FE] = 8'hC3;
      wait_idle();
      issue(8'hAF, 24'h000000, 8'h3C, 1, TP, 1, "R11 top"); mdl[16'h3FF] = 8'h3C;
      wait_idle();
      chk(aai_o == 1'b0, "R11 mode left at top", int'(aai_o), 0);
      check_mem("R11");

      chk(exq.size() == 0, "R7 all expected pulses seen", exq.size(), 0);
      finish_run();
   end
endmodule